// File: doc/BRIEF.md
# Interrupt Distributor State Registers

This block keeps the per-interrupt state of a small interrupt controller and makes it reachable through a word-addressed register port. For every interrupt it holds an enable bit, an active bit, a pending bit, an 8-bit priority and a trigger mode (level or edge). Each interrupt also has a line input from its peripheral. The packed pending, enable and priority vectors go out to a downstream selector, which picks the interrupt to deliver.

Enable, pending and active each have a set bank and a clear bank. A 1 in a written word acts on its interrupt and a 0 leaves that interrupt alone. A read of either bank of a pair returns the current state. A level-triggered interrupt is pending while its line is high or while a latch set by software is set. An edge-triggered interrupt latches a rising edge of its line. Configuration of the 32 private interrupts cannot be changed.

Reads are combinational from `bus_addr`. A write on `bus_wr` takes effect at the next rising clock edge. Only aligned 32-bit words are accepted.

Top module: `irq_dist_regs`

## Requirements
- R1: Reset clears all enable, active, stored-pending and software-latch bits, sets every priority to 0 and makes every interrupt level-triggered.
- R2: A write to the enable-set bank (byte 0x000 + 4w) sets the enable of interrupt 32w+b for each 1 in bit b. A write to the enable-clear bank (0x080 + 4w) clears it the same way. Zero bits change nothing. Reading either bank returns the enable bits, and `en_vec` shows them.
- R3: The active-set bank (0x200) and active-clear bank (0x280) behave like the enable banks for the active bits. Reading either one returns the active bits.
- R4: For a level-triggered interrupt, pending equals line OR software latch. A set-pending write (0x100 bank) sets the latch. A clear-pending write (0x180 bank) clears it, so pending then follows the line. Pending reads from both banks return the current pending bits and match `pend_vec`.
- R5: An edge-triggered interrupt becomes pending one clock after its line rises, or after a set-pending write. A clear-pending write clears it. When a rising edge and a clear fall in the same cycle, the interrupt stays pending.
- R6: Priority bank at 0x400: byte lane k of word w belongs to interrupt 4w+k. Only the top PRI_BITS bits of each byte are stored and the lower bits read back as 0. `prio_vec[8i+7:8i]` carries the stored byte of interrupt i.
- R7: Configuration bank at 0x800: in word w, bit 2k+1 gives the mode of interrupt 16w+k (1 = edge, 0 = level) and bit 2k is ignored. Reads return 2'b10 for edge and 2'b00 for level. Writes to interrupts below 32 have no effect.
- R8: Switching an interrupt to level recomputes its pending bit as line OR latch. Switching it to edge keeps its current pending value.
- R9: Words beyond NUM_IRQ in any bank, and offsets outside the mapped banks, read as 0 and ignore writes.
- R10: An access whose address bits [1:0] are not zero reads as 0 and is ignored when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 12 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| line_in | input | NUM_IRQ | Line level from each peripheral |
| pend_vec | output | NUM_IRQ | Pending bit of each interrupt |
| en_vec | output | NUM_IRQ | Enable bit of each interrupt |
| prio_vec | output | 8*NUM_IRQ | Priority byte of each interrupt |

## Verification
Most state is visible at the ports in the clock after the write that changed it, and reads are combinational, so a wrong bit shows on the next read or on the vector outputs one cycle later. The software latch is the exception. It has no read path of its own and only shows through the pending bit of a level interrupt. It can stay hidden while the line is high, or while the interrupt is edge-triggered, and it appears only when the line drops or the mode switches back to level. The bench therefore drives those transitions on purpose. A wrong edge detector shows one clock after the line rises.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    typedef enum logic [3:0] {
        BK_NONE,
        BK_EN_SET,
        BK_EN_CLR,
        BK_PD_SET,
        BK_PD_CLR,
        BK_AC_SET,
        BK_AC_CLR,
        BK_PRIO,
        BK_CFG
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [7:0] word;
    } dec_t;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
        logic ac_set;
        logic ac_clr;
        logic cfg_wr;
        logic cfg_edge;
    } irq_cmd_t;

    typedef struct packed {
        logic en;
        logic act;
        logic pend;
        logic edge_cfg;
    } irq_stat_t;

    localparam int PRIV_IRQS = 32;

    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic [7:0] prio_mask(input int pbits);
        return 8'hFF << (8 - pbits);
    endfunction

    // Offset map: [11:10]=00 bit banks, sub-bank in [9:7]; 01 priority; 10 with [9:8]=00 config
    function automatic dec_t decode_addr(input logic [11:0] a);
        dec_t d;
        d.bank = BK_NONE;
        d.word = '0;
        case (a[11:10])
            2'b00: begin
                d.word = {3'b000, a[6:2]};
                case (a[9:7])
                    3'd0:    d.bank = BK_EN_SET;
                    3'd1:    d.bank = BK_EN_CLR;
                    3'd2:    d.bank = BK_PD_SET;
                    3'd3:    d.bank = BK_PD_CLR;
                    3'd4:    d.bank = BK_AC_SET;
                    3'd5:    d.bank = BK_AC_CLR;
                    default: d.bank = BK_NONE;
                endcase
            end
            2'b01: begin
                d.bank = BK_PRIO;
                d.word = a[9:2];
            end
            2'b10: begin
                if (a[9:8] == 2'b00) begin
                    d.bank = BK_CFG;
                    d.word = {2'b00, a[7:2]};
                end
            end
            default: d.bank = BK_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [11:0] addr,
    output dec_t        dec,
    output logic        hit
);
    localparam int NW_BIT  = NUM_IRQ / 32;
    localparam int NW_PRIO = NUM_IRQ / 4;
    localparam int NW_CFG  = NUM_IRQ / 16;

    dec_t d_raw;
    logic in_range;

    always_comb begin
        d_raw = decode_addr(addr);
        case (d_raw.bank)
            BK_PRIO: in_range = (int'(d_raw.word) < NW_PRIO);
            BK_CFG:  in_range = (int'(d_raw.word) < NW_CFG);
            BK_NONE: in_range = 1'b0;
            default: in_range = (int'(d_raw.word) < NW_BIT);
        endcase
    end

    assign dec = d_raw;
    assign hit = in_range && (addr[1:0] == 2'b00);

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell
    import irq_dist_pkg::*;
#(
    parameter bit IS_PRIVATE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  irq_cmd_t  cmd,
    input  logic      line,
    output irq_stat_t stat
);
    logic en_q, act_q, soft_q, pend_e_q, edge_q, line_q;
    logic rise, lvl_pend, cfg_take;

    assign rise     = line & ~line_q;
    assign lvl_pend = line | soft_q;
    assign cfg_take = cmd.cfg_wr && !IS_PRIVATE;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            act_q    <= 1'b0;
            soft_q   <= 1'b0;
            pend_e_q <= 1'b0;
            edge_q   <= 1'b0;
            line_q   <= 1'b0;
        end else begin
            line_q <= line;

            if (cmd.en_set)      en_q <= 1'b1;
            else if (cmd.en_clr) en_q <= 1'b0;

            if (cmd.ac_set)      act_q <= 1'b1;
            else if (cmd.ac_clr) act_q <= 1'b0;

            // software latch only moves while level-triggered
            if (!edge_q) begin
                if (cmd.pd_set)      soft_q <= 1'b1;
                else if (cmd.pd_clr) soft_q <= 1'b0;
            end

            if (cfg_take) edge_q <= cmd.cfg_edge;

            if (!edge_q) begin
                // entering edge mode keeps the pending value seen so far
                if (cfg_take && cmd.cfg_edge) pend_e_q <= lvl_pend;
            end else if (cmd.pd_set || rise) begin
                pend_e_q <= 1'b1;
            end else if (cmd.pd_clr) begin
                pend_e_q <= 1'b0;
            end
        end
    end

    assign stat.en       = en_q;
    assign stat.act      = act_q;
    assign stat.edge_cfg = edge_q;
    assign stat.pend     = edge_q ? pend_e_q : lvl_pend;

    p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.en_set |=> stat.en);
    p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.en_clr && !cmd.en_set) |=> !stat.en);
    p_act_set_r3: assert property (@(posedge clk) disable iff (rst)
        cmd.ac_set |=> stat.act);
    p_act_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.ac_clr && !cmd.ac_set) |=> !stat.act);
    p_level_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.pd_clr && !cmd.pd_set && !stat.edge_cfg && !cmd.cfg_wr) |=> (stat.pend == line));
    p_edge_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (stat.edge_cfg && rise && !cmd.cfg_wr) |=> stat.pend);
    p_to_edge_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_take && cmd.cfg_edge && !stat.edge_cfg) |=> (stat.pend == $past(stat.pend)));

endmodule

// File: rtl/irq_prio_slot.sv
module irq_prio_slot
    import irq_dist_pkg::*;
#(
    parameter int PRI_BITS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wbyte,
    output logic [7:0] prio
);
    localparam logic [7:0] PMASK = prio_mask(PRI_BITS);

    logic [7:0] prio_q;

    always_ff @(posedge clk) begin
        if (rst)     prio_q <= '0;
        else if (wr) prio_q <= wbyte & PMASK;
    end

    assign prio = prio_q;

    p_prio_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(prio));
    p_prio_top_r6: assert property (@(posedge clk) disable iff (rst)
        wr |=> (prio[7:8-PRI_BITS] == $past(wbyte[7:8-PRI_BITS])));

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int PRI_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_IRQ-1:0]   line_in,
    output logic [NUM_IRQ-1:0]   pend_vec,
    output logic [NUM_IRQ-1:0]   en_vec,
    output logic [8*NUM_IRQ-1:0] prio_vec
);
    localparam int NW_BIT  = NUM_IRQ / 32;
    localparam int NW_PRIO = NUM_IRQ / 4;
    localparam int NW_CFG  = NUM_IRQ / 16;
    localparam int IW_BIT  = idx_w(NW_BIT);
    localparam int IW_PRIO = idx_w(NW_PRIO);
    localparam int IW_CFG  = idx_w(NW_CFG);

    dec_t dec;
    logic hit, wr_ok;

    irq_addr_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .addr (bus_addr),
        .dec  (dec),
        .hit  (hit)
    );

    assign wr_ok = bus_wr && hit;

    logic [NUM_IRQ-1:0] act_v, edge_v;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam int BW = i / 32;
        localparam int BB = i % 32;
        localparam int PW = i / 4;
        localparam int PB = i % 4;
        localparam int CW = i / 16;
        localparam int CB = i % 16;

        irq_cmd_t  cmd;
        irq_stat_t st;
        logic      bit_word, prio_wr;

        assign bit_word = (dec.word == 8'(BW)) && bus_wdata[BB];
        assign prio_wr  = wr_ok && (dec.bank == BK_PRIO) && (dec.word == 8'(PW));

        assign cmd.en_set   = wr_ok && (dec.bank == BK_EN_SET) && bit_word;
        assign cmd.en_clr   = wr_ok && (dec.bank == BK_EN_CLR) && bit_word;
        assign cmd.pd_set   = wr_ok && (dec.bank == BK_PD_SET) && bit_word;
        assign cmd.pd_clr   = wr_ok && (dec.bank == BK_PD_CLR) && bit_word;
        assign cmd.ac_set   = wr_ok && (dec.bank == BK_AC_SET) && bit_word;
        assign cmd.ac_clr   = wr_ok && (dec.bank == BK_AC_CLR) && bit_word;
        assign cmd.cfg_wr   = wr_ok && (dec.bank == BK_CFG) && (dec.word == 8'(CW));
        assign cmd.cfg_edge = bus_wdata[2*CB+1];

        irq_state_cell #(.IS_PRIVATE(i < PRIV_IRQS)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .cmd  (cmd),
            .line (line_in[i]),
            .stat (st)
        );

        irq_prio_slot #(.PRI_BITS(PRI_BITS)) u_prio (
            .clk   (clk),
            .rst   (rst),
            .wr    (prio_wr),
            .wbyte (bus_wdata[8*PB +: 8]),
            .prio  (prio_vec[8*i +: 8])
        );

        assign en_vec[i]   = st.en;
        assign act_v[i]    = st.act;
        assign pend_vec[i] = st.pend;
        assign edge_v[i]   = st.edge_cfg;
    end

    // read-side word arrays, padded to a power of two so the index never overruns
    logic [2**IW_BIT-1:0][31:0]  en_w, pd_w, ac_w;
    logic [2**IW_PRIO-1:0][31:0] pr_w;
    logic [2**IW_CFG-1:0][31:0]  cf_w;

    for (genvar w = 0; w < 2**IW_BIT; w++) begin : g_bw
        if (w < NW_BIT) begin : g_on
            assign en_w[w] = en_vec[32*w +: 32];
            assign pd_w[w] = pend_vec[32*w +: 32];
            assign ac_w[w] = act_v[32*w +: 32];
        end else begin : g_off
            assign en_w[w] = '0;
            assign pd_w[w] = '0;
            assign ac_w[w] = '0;
        end
    end

    for (genvar w = 0; w < 2**IW_PRIO; w++) begin : g_pw
        if (w < NW_PRIO) begin : g_on
            assign pr_w[w] = prio_vec[32*w +: 32];
        end else begin : g_off
            assign pr_w[w] = '0;
        end
    end

    for (genvar w = 0; w < 2**IW_CFG; w++) begin : g_cw
        if (w < NW_CFG) begin : g_on
            logic [31:0] fields;
            always_comb begin
                fields = '0;
                for (int k = 0; k < 16; k++) fields[2*k+1] = edge_v[16*w+k];
            end
            assign cf_w[w] = fields;
        end else begin : g_off
            assign cf_w[w] = '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (dec.bank)
                BK_EN_SET, BK_EN_CLR: bus_rdata = en_w[dec.word[IW_BIT-1:0]];
                BK_PD_SET, BK_PD_CLR: bus_rdata = pd_w[dec.word[IW_BIT-1:0]];
                BK_AC_SET, BK_AC_CLR: bus_rdata = ac_w[dec.word[IW_BIT-1:0]];
                BK_PRIO:              bus_rdata = pr_w[dec.word[IW_PRIO-1:0]];
                BK_CFG:               bus_rdata = cf_w[dec.word[IW_CFG-1:0]];
                default:              bus_rdata = '0;
            endcase
        end
    end

    p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));
    p_private_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (decode_addr(bus_addr).bank == BK_CFG)) |=> $stable(edge_v[PRIV_IRQS-1:0]));
    p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (decode_addr(bus_addr).bank == BK_NONE)) |=> ($stable(en_vec) && $stable(act_v) && $stable(prio_vec)));

endmodule

// File: tb/irq_dist_regs_tb_top.sv
module irq_dist_regs_tb_top;

    localparam int NIRQ = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NIRQ-1:0]   line_in = '0;
    logic [NIRQ-1:0]   pend_vec, en_vec;
    logic [8*NIRQ-1:0] prio_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_dist_regs #(.NUM_IRQ(NIRQ), .PRI_BITS(5)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_in   (line_in),
        .pend_vec  (pend_vec),
        .en_vec    (en_vec),
        .prio_vec  (prio_vec)
    );

    // entry: {is_write, addr[11:0], data[31:0]}; for reads data is the expected value
    localparam int NSTEP = 32;
    localparam logic [44:0] STEPS [NSTEP] = '{
        {1'b1, 12'h000, 32'h0000_00F0},  // R2 set enables 4..7
        {1'b0, 12'h000, 32'h0000_00F0},  // R2
        {1'b0, 12'h080, 32'h0000_00F0},  // R2 clear bank reads state
        {1'b1, 12'h080, 32'h0000_0030},  // R2 clear 4,5
        {1'b0, 12'h000, 32'h0000_00C0},  // R2
        {1'b1, 12'h004, 32'h8000_0001},  // R2 irq 32 and 63
        {1'b0, 12'h084, 32'h8000_0001},  // R2
        {1'b1, 12'h200, 32'h0000_0003},  // R3
        {1'b0, 12'h280, 32'h0000_0003},  // R3
        {1'b1, 12'h280, 32'h0000_0001},  // R3
        {1'b0, 12'h200, 32'h0000_0002},  // R3
        {1'b1, 12'h400, 32'hFFFF_FF13},  // R6 narrowed to top 5 bits
        {1'b0, 12'h400, 32'hF8F8_F810},  // R6
        {1'b1, 12'h43C, 32'h8040_2001},  // R6 irq 60..63
        {1'b0, 12'h43C, 32'h8040_2000},  // R6
        {1'b1, 12'h808, 32'h0000_000A},  // R7 irq 32,33 edge
        {1'b0, 12'h808, 32'h0000_000A},  // R7
        {1'b1, 12'h808, 32'h0000_0007},  // R7 low field bit ignored, 33 back to level
        {1'b0, 12'h808, 32'h0000_0002},  // R7
        {1'b1, 12'h800, 32'hFFFF_FFFF},  // R7 private ignored
        {1'b0, 12'h800, 32'h0000_0000},  // R7
        {1'b0, 12'h804, 32'h0000_0000},  // R7
        {1'b1, 12'h008, 32'hFFFF_FFFF},  // R9 word past NUM_IRQ
        {1'b0, 12'h008, 32'h0000_0000},  // R9
        {1'b0, 12'h000, 32'h0000_00C0},  // R9 no side effect
        {1'b1, 12'h300, 32'hFFFF_FFFF},  // R9 unmapped sub-bank
        {1'b0, 12'h300, 32'h0000_0000},  // R9
        {1'b1, 12'h001, 32'hFFFF_FFFF},  // R10 misaligned write
        {1'b0, 12'h000, 32'h0000_00C0},  // R10
        {1'b0, 12'h001, 32'h0000_0000},  // R10 misaligned read
        {1'b0, 12'hC00, 32'h0000_0000},  // R9 unmapped region
        {1'b0, 12'h810, 32'h0000_0000}   // R9 config word past NUM_IRQ
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check({32'h0, bus_rdata}, {32'h0, exp}, tag);
    endtask

    task automatic line_set(input int idx, input logic v);
        @(negedge clk);
        line_in[idx] = v;
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check(en_vec, 64'h0, "R1 en_vec");
        check(pend_vec, 64'h0, "R1 pend_vec");
        check({32'h0, prio_vec[31:0]}, 64'h0, "R1 prio");
        rd_chk(12'h200, 32'h0, "R1 active");
        rd_chk(12'h808, 32'h0, "R1 all level");

        for (int s = 0; s < NSTEP; s++) begin
            if (STEPS[s][44]) wr_reg(STEPS[s][43:32], STEPS[s][31:0]);
            else              rd_chk(STEPS[s][43:32], STEPS[s][31:0], $sformatf("table step %0d", s));
        end

        check(en_vec, 64'h8000_0001_0000_00C0, "R2 en_vec");
        check({32'h0, prio_vec[31:0]}, {32'h0, 32'hF8F8_F810}, "R6 prio_vec low");
        check({32'h0, prio_vec[511:480]}, {32'h0, 32'h8040_2000}, "R6 prio_vec high");

        // R4 level irq 40: word 1 bit 8
        line_set(40, 1'b1);
        check({63'h0, pend_vec[40]}, 64'h1, "R4 follows line high");
        rd_chk(12'h104, 32'h0000_0100, "R4 pend read");
        line_set(40, 1'b0);
        check({63'h0, pend_vec[40]}, 64'h0, "R4 follows line low");
        wr_reg(12'h104, 32'h0000_0100);
        #1 check({63'h0, pend_vec[40]}, 64'h1, "R4 latch sets");
        rd_chk(12'h184, 32'h0000_0100, "R4 clear bank read");
        line_set(40, 1'b1);
        wr_reg(12'h184, 32'h0000_0100);
        #1 check({63'h0, pend_vec[40]}, 64'h1, "R4 clear with line high");
        line_set(40, 1'b0);
        check({63'h0, pend_vec[40]}, 64'h0, "R4 latch gone");

        // R5 edge irq 32
        wr_reg(12'h184, 32'h0000_0001);
        line_set(32, 1'b1);
        check({63'h0, pend_vec[32]}, 64'h1, "R5 rising edge");
        line_set(32, 1'b0);
        check({63'h0, pend_vec[32]}, 64'h1, "R5 held after fall");
        wr_reg(12'h184, 32'h0000_0001);
        #1 check({63'h0, pend_vec[32]}, 64'h0, "R5 clear");
        wr_reg(12'h104, 32'h0000_0001);
        #1 check({63'h0, pend_vec[32]}, 64'h1, "R5 set write");
        wr_reg(12'h184, 32'h0000_0001);
        #1 check({63'h0, pend_vec[32]}, 64'h0, "R5 clear again");
        @(negedge clk);
        line_in[32] = 1'b1;
        bus_wr = 1'b1; bus_addr = 12'h184; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check({63'h0, pend_vec[32]}, 64'h1, "R5 edge beats clear");
        line_set(32, 1'b0);

        // R8 irq 33 mode switches with latch set
        wr_reg(12'h104, 32'h0000_0002);
        #1 check({63'h0, pend_vec[33]}, 64'h1, "R8 latch set");
        wr_reg(12'h808, 32'h0000_000A);
        #1 check({63'h0, pend_vec[33]}, 64'h1, "R8 to edge keeps pending");
        wr_reg(12'h184, 32'h0000_0002);
        #1 check({63'h0, pend_vec[33]}, 64'h0, "R8 edge clear");
        wr_reg(12'h808, 32'h0000_0002);
        #1 check({63'h0, pend_vec[33]}, 64'h1, "R8 back to level recomputes");
        wr_reg(12'h184, 32'h0000_0002);
        #1 check({63'h0, pend_vec[33]}, 64'h0, "R8 level clear");

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule